// File: doc/BRIEF.md
# Instruction Decode and Timing Generator

This block is the front end of the control section in a 16-bit accumulator machine. It keeps a 4-bit step counter and turns it into sixteen timing lines, with exactly one line high at any time. The control equations downstream use these lines to order the micro-operations of each instruction. Each step the counter either moves forward, drops back to the first step, or stays where it is. At the end of the sixteenth step it wraps back to the first step by itself.

The block also takes the instruction word that the instruction register holds. Bits 14..12 of that word select one of eight opcode lines, and bits 11..0 pass straight through as the operand address. A mode flag takes bit 15 of the word when a load strobe asks for it. The flag reads 0 for a direct address and 1 for an indirect one. The control equations, the memory and the instruction register itself sit outside this block.

Top module: `instrDecodeTiming`

## Requirements
- R1: While the active-low reset `rstN` is low, and after it is released until the first counter action, the step count is 0, so `timing` equals 16'h0001 (bit 0, the first step, is high) and `indirect` is 0.
- R2: At every cycle exactly one bit of `timing` is high, and that bit's index is the current step count.
- R3: A rising clock edge with `seqInc`=1 and `seqClr`=0 moves the high `timing` bit from index k to index k+1.
- R4: When `seqInc`=1 and `seqClr`=0 and `timing` bit 15 is high, the next edge makes `timing` bit 0 high (wrap).
- R5: A rising edge with `seqClr`=1 makes `timing` bit 0 high on the next cycle, whatever the value of `seqInc`. Clear wins over increment.
- R6: A rising edge with `seqInc`=0 and `seqClr`=0 leaves `timing` unchanged.
- R7: `opLines` is one-hot, and its high bit index equals `instrWord[14:12]`. It follows the input word in the same cycle, with no register on the path.
- R8: `addrField` equals `instrWord[11:0]` in the same cycle.
- R9: A rising edge with `loadMode`=1 loads `instrWord[15]` into `indirect`, where 0 means direct and 1 means indirect. With `loadMode`=0, `indirect` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| instrWord | input | 16 | Instruction word: [15] mode, [14:12] opcode, [11:0] address |
| seqInc | input | 1 | Advance the step counter |
| seqClr | input | 1 | Return the step counter to step 0 (has priority) |
| loadMode | input | 1 | Load the mode flag from instrWord[15] |
| timing | output | 16 | One-hot step lines, bit k high at step k |
| opLines | output | 8 | One-hot opcode lines |
| addrField | output | 12 | Operand address field |
| indirect | output | 1 | Mode flag, 1 = indirect |

## Verification
The bench uses the default parameters: a 12-bit address field, a 3-bit opcode and a 4-bit step counter. These values are small enough that a directed pass can walk the counter through all sixteen steps and the wrap. They also let the bench drive all eight opcode codes one by one. Random steps with a fixed seed then bring a clear in at many different counter values, often in the same cycle as an increment. They also mix hold cycles and mode loads among them, and the bench checks every result against a model of the counter and flag that it keeps itself.

// File: rtl/idt_pkg.sv
package idt_pkg;

  // Strobes from the control side to the datapath side
  typedef struct packed {
    logic stepAdvance;
    logic stepRestart;
    logic modeCapture;
  } idtStrobes_t;

endpackage

// File: rtl/idtOneHot.sv
module idtOneHot #(
  parameter int SEL_W = 3,
  localparam int LINES = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  output logic [LINES-1:0] lines
);

  for (genvar g = 0; g < LINES; g++) begin : gLine
    assign lines[g] = (sel == SEL_W'(g));
  end

endmodule

// File: rtl/idtControl.sv
module idtControl
  import idt_pkg::*;
(
  input  logic        seqInc,
  input  logic        seqClr,
  input  logic        loadMode,
  output idtStrobes_t strobes
);

  // Clear has priority over increment
  always_comb begin
    strobes.stepRestart = seqClr;
    strobes.stepAdvance = seqInc & ~seqClr;
    strobes.modeCapture = loadMode;
  end

endmodule

// File: rtl/idtDatapath.sv
module idtDatapath
  import idt_pkg::*;
#(
  parameter int SC_W = 4,
  parameter int OP_W = 3,
  localparam int NUM_T = 1 << SC_W,
  localparam int NUM_OP = 1 << OP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  idtStrobes_t       strobes,
  input  logic              modeBit,
  input  logic [OP_W-1:0]   opField,
  output logic [NUM_T-1:0]  timing,
  output logic [NUM_OP-1:0] opLines,
  output logic              indirect
);

  logic [SC_W-1:0] stepCount;
  logic            modeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCount <= '0;
    end else if (strobes.stepRestart) begin
      stepCount <= '0;
    end else if (strobes.stepAdvance) begin
      stepCount <= stepCount + SC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= 1'b0;
    end else if (strobes.modeCapture) begin
      modeReg <= modeBit;
    end
  end

  assign indirect = modeReg;

  idtOneHot #(.SEL_W(SC_W)) uStepDec (
    .sel   (stepCount),
    .lines (timing)
  );

  idtOneHot #(.SEL_W(OP_W)) uOpDec (
    .sel   (opField),
    .lines (opLines)
  );

  AST_TIMING_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(timing) == 1); // R2
  AST_OP_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(opLines) == 1); // R7
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepAdvance && !strobes.stepRestart)
      |=> stepCount == $past(stepCount) + SC_W'(1)); // R3
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepAdvance && timing[NUM_T-1]) |=> timing[0]); // R4
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepRestart |=> timing[0]); // R5
  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.stepAdvance && !strobes.stepRestart) |=> $stable(timing)); // R6
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.modeCapture |=> $stable(indirect)); // R9
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.modeCapture |=> indirect == $past(modeBit)); // R9

endmodule

// File: rtl/instrDecodeTiming.sv
module instrDecodeTiming
  import idt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OP_W = 3,
  parameter int SC_W = 4,
  localparam int WORD_W = ADDR_W + OP_W + 1,
  localparam int NUM_T = 1 << SC_W,
  localparam int NUM_OP = 1 << OP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] instrWord,
  input  logic              seqInc,
  input  logic              seqClr,
  input  logic              loadMode,
  output logic [NUM_T-1:0]  timing,
  output logic [NUM_OP-1:0] opLines,
  output logic [ADDR_W-1:0] addrField,
  output logic              indirect
);

  idtStrobes_t strobes;

  idtControl uCtrl (
    .seqInc   (seqInc),
    .seqClr   (seqClr),
    .loadMode (loadMode),
    .strobes  (strobes)
  );

  idtDatapath #(.SC_W(SC_W), .OP_W(OP_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .modeBit  (instrWord[WORD_W-1]),
    .opField  (instrWord[WORD_W-2:ADDR_W]),
    .timing   (timing),
    .opLines  (opLines),
    .indirect (indirect)
  );

  assign addrField = instrWord[ADDR_W-1:0];

endmodule

// File: tb/instrDecodeTiming_test.sv
module instrDecodeTiming_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] instrWord = '0;
  logic        seqInc = 1'b0;
  logic        seqClr = 1'b0;
  logic        loadMode = 1'b0;
  logic [15:0] timing;
  logic [7:0]  opLines;
  logic [11:0] addrField;
  logic        indirect;

  int checks = 0;
  int errors = 0;
  int expCount = 0;
  logic expMode = 1'b0;
  bit finished = 0;

  always #4 clk = ~clk;

  instrDecodeTiming uut (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .seqInc(seqInc),
    .seqClr(seqClr), .loadMode(loadMode), .timing(timing),
    .opLines(opLines), .addrField(addrField), .indirect(indirect)
  );

  function automatic logic [15:0] expTiming(int c);
    return 16'(1) << c;
  endfunction

  function automatic logic [7:0] expOp(logic [15:0] w);
    return 8'(1) << w[14:12];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check combinational, clock, check registered
  task automatic step(string req, logic inc, logic clr, logic ld, logic [15:0] w);
    @(negedge clk);
    seqInc = inc; seqClr = clr; loadMode = ld; instrWord = w;
    #1;
    check("R7", 32'(opLines), 32'(expOp(w)));
    check("R8", 32'(addrField), 32'(w[11:0]));
    @(posedge clk);
    if (clr) expCount = 0;
    else if (inc) expCount = (expCount + 1) % 16;
    if (ld) expMode = w[15];
    #2;
    check(req, 32'(timing), 32'(expTiming(expCount)));
    check("R9", 32'(indirect), 32'(expMode));
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    void'($urandom(32'd1357));
    #3;
    check("R1", 32'(timing), 32'h0001);  // in reset
    check("R1", 32'(indirect), 32'h0);
    repeat (2) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1", 32'(timing), 32'h0001);
    // Walk all 16 steps and wrap
    for (int i = 0; i < 15; i++) step("R3", 1, 0, 0, 16'h0123);
    check("R2", 32'(timing), 32'h8000);
    step("R4", 1, 0, 0, 16'h0456);
    // Hold
    step("R3", 1, 0, 0, 16'h1000);
    step("R6", 0, 0, 0, 16'h2abc);
    step("R6", 0, 0, 0, 16'h3def);
    // Clear with and without increment
    step("R3", 1, 0, 0, 16'h4000);
    step("R5", 1, 1, 0, 16'h5000);
    step("R3", 1, 0, 0, 16'h6000);
    step("R5", 0, 1, 0, 16'h7000);
    // Mode load and hold
    step("R9", 0, 0, 1, 16'h8fff);
    step("R9", 0, 0, 0, 16'h0000);
    step("R9", 0, 0, 1, 16'h7fff);
    // Every opcode
    for (int op = 0; op < 8; op++)
      step("R7", 1, 0, 0, {1'b0, 3'(op), 12'(op * 273)});
    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic clr, inc, ld;
      logic [15:0] w;
      clr = ($urandom % 8) == 0;
      inc = ($urandom % 4) != 0;
      ld = ($urandom % 4) == 0;
      w = 16'($urandom);
      step(clr ? "R5" : (inc ? "R3" : "R6"), inc, clr, ld, w);
    end
    // Reset mid-run returns to step 0
    step("R3", 1, 0, 1, 16'h8000);
    @(negedge clk); rstN = 1'b0; #1;
    expCount = 0; expMode = 1'b0;
    check("R1", 32'(timing), 32'h0001);
    check("R1", 32'(indirect), 32'h0);
    finish();
  end

endmodule